// File: doc/BRIEF.md
# Signed Hardware Divider Peripheral

This peripheral divides a 32-bit signed dividend by a 16-bit signed divisor. It sits behind a plain register port: an address, a write strobe, write data and a combinational read-data return. Software first stores the dividend. It then writes the divisor, and that write alone launches the division. When the calculation is finished, software reads back the quotient, the remainder (sign-extended to 32 bits) and a status word.

The core is a restoring radix-2 divider that works on magnitudes. It produces one quotient bit per clock, so a result takes 32 cycles, and the signs are applied as the result is stored. The result registers keep the previous answer until the new one is stored. A zero divisor skips the iteration: the block stores fixed values at once and raises a flag. The status word and two pins report the progress of a calculation: a busy level, and a done pulse that lasts one cycle.

Top module: `sdiv_mmio`

Register offsets: dividend 0x00, divisor 0x04, quotient 0x08, remainder 0x0C, status 0x10.

## Requirements
- R1: The dividend register at 0x00 is read/write and reads back all 32 bits. The divisor register at 0x04 keeps write bits [15:0] and reads them back with bits [31:16] as zero.
- R2: A write to 0x04 with a non-zero value in bits [15:0] sets busy (the `div_busy` pin and status bit 0). Busy stays high for exactly 32 cycles. In the cycle busy falls, `div_done` is high for one cycle, and the new results are readable in that same cycle.
- R3: The quotient at 0x08 is the signed quotient truncated toward zero, as a 32-bit two's complement value. The case -2^31 / -1 yields 0x80000000.
- R4: The remainder takes the sign of the dividend, so that dividend = quotient × divisor + remainder. It sits in bits [15:0] at 0x0C, and bits [31:16] copy bit 15.
- R5: While busy is high, reads of the quotient and the remainder return the previous result.
- R6: A divisor write with bits [15:0] equal to zero sets status bit 1 (the divide-by-zero flag). It loads the quotient with 0xFFFFFFFF and the remainder with the dividend's bits [15:0] sign-extended. It leaves busy low, and it pulses `div_done` in the following cycle.
- R7: Every divisor write updates the divide-by-zero flag. A non-zero divisor write clears it.
- R8: A divisor write while busy abandons the running calculation. It restarts with the dividend register's current value and the new divisor, and busy then lasts 32 cycles counted from that latest write.
- R9: Writes to 0x08, 0x0C and 0x10 have no effect. Status bits [31:2] read as zero, and any offset not listed reads as zero.
- R10: After reset, every register reads zero, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 5 | Byte offset of the register accessed |
| reg_we | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| div_busy | output | 1 | High while a division is in progress |
| div_done | output | 1 | One-cycle pulse once results are stored |

## Verification
Two kinds of internal fault show up at the ports right away. A wrong iteration counter changes the busy length away from 32 cycles. A lost start leaves busy low in the cycle after the divisor write. Both appear before any result is read. A wrong partial remainder or a wrong sign fix-up surfaces only when the quotient and remainder are read after done. The bench compares them with values computed from signed arithmetic over random operands and over the corner cases: zero divisor, ±1, -32768, the most negative dividend, and a restart in mid-calculation.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  localparam int unsigned OFS_DVD = 32'h00;
  localparam int unsigned OFS_DSR = 32'h04;
  localparam int unsigned OFS_QUO = 32'h08;
  localparam int unsigned OFS_REM = 32'h0C;
  localparam int unsigned OFS_STS = 32'h10;
  localparam int unsigned STS_BUSY_BIT = 0;
  localparam int unsigned STS_DBZ_BIT  = 1;
endpackage

// File: rtl/sdiv_core.sv
// Restoring radix-2 divider on magnitudes; signs applied on the final step.
module sdiv_core #(
  parameter int unsigned DVD_W = 32,
  parameter int unsigned DSR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             zero_i,
  input  logic [DVD_W-1:0] dvd_i,
  input  logic [DSR_W-1:0] dsr_i,
  output logic             busy_o,
  output logic             fin_o,
  output logic [DVD_W-1:0] quo_o,
  output logic [DSR_W-1:0] rem_o
);
  localparam int unsigned CNT_W = $clog2(DVD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DVD_W - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DVD_W-1:0] acc_q;
  logic [DSR_W-1:0] part_q;
  logic [DSR_W-1:0] den_q;
  logic             negq_q, negr_q;

  logic [DSR_W:0]   shifted, trial;
  logic             ge;
  logic [DSR_W-1:0] part_nx;
  logic [DVD_W-1:0] acc_nx;
  logic [DVD_W-1:0] dvd_mag;
  logic [DSR_W-1:0] dsr_mag;

  always_comb begin
    dvd_mag = dvd_i[DVD_W-1] ? (~dvd_i + 1'b1) : dvd_i;
    dsr_mag = dsr_i[DSR_W-1] ? (~dsr_i + 1'b1) : dsr_i;
    shifted = {part_q, acc_q[DVD_W-1]};
    trial   = shifted - {1'b0, den_q};
    ge      = ~trial[DSR_W];
    part_nx = ge ? trial[DSR_W-1:0] : shifted[DSR_W-1:0];
    acc_nx  = {acc_q[DVD_W-2:0], ge};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      part_q <= '0;
      den_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= ~zero_i;
      cnt_q  <= '0;
      acc_q  <= dvd_mag;
      part_q <= '0;
      den_q  <= dsr_mag;
      negq_q <= dvd_i[DVD_W-1] ^ dsr_i[DSR_W-1];
      negr_q <= dvd_i[DVD_W-1];
    end else if (busy_q) begin
      acc_q  <= acc_nx;
      part_q <= part_nx;
      cnt_q  <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign fin_o  = busy_q && (cnt_q == LAST) && !start_i;
  assign quo_o  = negq_q ? (~acc_nx + 1'b1) : acc_nx;
  assign rem_o  = negr_q ? (~part_nx + 1'b1) : part_nx;
endmodule

// File: rtl/sdiv_regs.sv
// Register decode, result storage and read multiplexer.
module sdiv_regs
  import sdiv_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DVD_W  = 32,
  parameter int unsigned DSR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DVD_W-1:0]  wdata_i,
  output logic [DVD_W-1:0]  rdata_o,
  input  logic              busy_i,
  input  logic              fin_i,
  input  logic [DVD_W-1:0]  quo_i,
  input  logic [DSR_W-1:0]  rem_i,
  output logic              start_o,
  output logic              zero_o,
  output logic [DVD_W-1:0]  dvd_o,
  output logic [DSR_W-1:0]  dsr_o,
  output logic              done_o
);
  localparam int unsigned EXT_W = DVD_W - DSR_W;

  logic [DVD_W-1:0] dvd_q, quo_q;
  logic [DSR_W-1:0] dsr_q, rem_q;
  logic             dbz_q, done_q;
  logic             wr_dvd, wr_dsr, wzero;

  assign wr_dvd = we_i && (addr_i == ADDR_W'(OFS_DVD));
  assign wr_dsr = we_i && (addr_i == ADDR_W'(OFS_DSR));
  assign wzero  = (wdata_i[DSR_W-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      dsr_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      dbz_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin_i || (wr_dsr && wzero);
      if (wr_dvd) dvd_q <= wdata_i;
      if (wr_dsr) begin
        dsr_q <= wdata_i[DSR_W-1:0];
        dbz_q <= wzero;
        if (wzero) begin
          quo_q <= '1;
          rem_q <= dvd_q[DSR_W-1:0];
        end
      end else if (fin_i) begin
        quo_q <= quo_i;
        rem_q <= rem_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFS_DVD): rdata_o = dvd_q;
      ADDR_W'(OFS_DSR): rdata_o = {{EXT_W{1'b0}}, dsr_q};
      ADDR_W'(OFS_QUO): rdata_o = quo_q;
      ADDR_W'(OFS_REM): rdata_o = {{EXT_W{rem_q[DSR_W-1]}}, rem_q};
      ADDR_W'(OFS_STS): begin
        rdata_o[STS_BUSY_BIT] = busy_i;
        rdata_o[STS_DBZ_BIT]  = dbz_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign start_o = wr_dsr;
  assign zero_o  = wzero;
  assign dvd_o   = dvd_q;
  assign dsr_o   = wdata_i[DSR_W-1:0];
  assign done_o  = done_q;
endmodule

// File: rtl/sdiv_mmio.sv
module sdiv_mmio #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DVD_W  = 32,
  parameter int unsigned DSR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DVD_W-1:0]  reg_wdata,
  output logic [DVD_W-1:0]  reg_rdata,
  output logic              div_busy,
  output logic              div_done
);
  logic             start, zero, busy, fin;
  logic [DVD_W-1:0] dvd, quo;
  logic [DSR_W-1:0] dsr, rem;

  sdiv_regs #(.ADDR_W(ADDR_W), .DVD_W(DVD_W), .DSR_W(DSR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(reg_addr), .we_i(reg_we),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .busy_i(busy), .fin_i(fin),
    .quo_i(quo), .rem_i(rem), .start_o(start), .zero_o(zero),
    .dvd_o(dvd), .dsr_o(dsr), .done_o(div_done)
  );

  sdiv_core #(.DVD_W(DVD_W), .DSR_W(DSR_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start_i(start), .zero_i(zero),
    .dvd_i(dvd), .dsr_i(dsr), .busy_o(busy), .fin_o(fin),
    .quo_o(quo), .rem_o(rem)
  );

  assign div_busy = busy;
endmodule

// File: rtl/sdiv_mmio_chk.sv
module sdiv_mmio_chk
  import sdiv_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DVD_W  = 32,
  parameter int unsigned DSR_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [DVD_W-1:0]  reg_wdata,
  input logic [DVD_W-1:0]  reg_rdata,
  input logic              div_busy,
  input logic              div_done
);
  logic dsr_wr;
  assign dsr_wr = reg_we && (reg_addr == ADDR_W'(OFS_DSR));

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dsr_wr && (reg_wdata[DSR_W-1:0] != '0) |=> div_busy);

  a_r6_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    dsr_wr && (reg_wdata[DSR_W-1:0] == '0) |=> !div_busy && div_done);

  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> !div_busy);

  a_r2_status_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFS_STS)) |-> (reg_rdata[STS_BUSY_BIT] == div_busy));

  a_r9_status_unused: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFS_STS)) |-> (reg_rdata[DVD_W-1:2] == '0));

  a_r4_rem_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFS_REM)) |->
      (reg_rdata[DVD_W-1:DSR_W] == {(DVD_W-DSR_W){reg_rdata[DSR_W-1]}}));

  a_r5_quo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy && $past(div_busy) && (reg_addr == ADDR_W'(OFS_QUO)) &&
    ($past(reg_addr) == ADDR_W'(OFS_QUO)) |-> $stable(reg_rdata));
endmodule

bind sdiv_mmio sdiv_mmio_chk #(.ADDR_W(ADDR_W), .DVD_W(DVD_W), .DSR_W(DSR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .div_busy(div_busy),
  .div_done(div_done)
);

// File: tb/sdiv_mmio_tb.sv
module sdiv_mmio_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        div_busy, div_done;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sdiv_mmio u_dut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .div_busy(div_busy), .div_done(div_done));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] exp_quo(input logic [31:0] dvd, input logic [15:0] dsr);
    longint q;
    if (dsr == 16'h0) return 32'hFFFF_FFFF;
    q = longint'($signed(dvd)) / longint'($signed(dsr));
    return q[31:0];
  endfunction

  function automatic logic [31:0] exp_rem(input logic [31:0] dvd, input logic [15:0] dsr);
    longint r;
    if (dsr == 16'h0) return {{16{dvd[15]}}, dvd[15:0]};
    r = longint'($signed(dvd)) % longint'($signed(dsr));
    return {{16{r[15]}}, r[15:0]};
  endfunction

  // Full divide: dividend, divisor, then wait and compare results (R2, R3, R4, R6, R7)
  task automatic run_div(input logic [31:0] dvd, input logic [15:0] dsr);
    logic [31:0] v;
    int cyc;
    wr(5'h00, dvd);
    wr(5'h04, {$urandom_range(0, 16'hFFFF), dsr});
    if (dsr == 16'h0) begin
      check("R6 busy stays low", {31'b0, div_busy}, 32'h0);
      check("R6 done pulse", {31'b0, div_done}, 32'h1);
    end else begin
      cyc = 0;
      while (div_busy && cyc < 100) begin cyc++; @(negedge clk); end
      check("R2 busy length", cyc, 32);
      check("R2 done at end", {31'b0, div_done}, 32'h1);
    end
    rd(5'h08, v); check("R3 quotient", v, exp_quo(dvd, dsr));
    rd(5'h0C, v); check("R4 remainder", v, exp_rem(dvd, dsr));
    rd(5'h10, v); check("R7 status flag", v, {30'b0, (dsr == 16'h0), 1'b0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, prev_q;
    int cyc;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    for (int a = 0; a <= 16; a += 4) begin
      rd(a[4:0], v); check("R10 reset value", v, 32'h0);
    end
    check("R10 busy low", {31'b0, div_busy}, 0);
    check("R10 done low", {31'b0, div_done}, 0);

    // R1: readback
    wr(5'h00, 32'hDEAD_BEEF); rd(5'h00, v); check("R1 dividend readback", v, 32'hDEAD_BEEF);
    wr(5'h04, 32'hABCD_8001); rd(5'h04, v); check("R1 divisor readback", v, 32'h0000_8001);
    while (div_busy) @(negedge clk);

    // Directed corner cases
    run_div(32'd100, 16'd7);
    run_div(-32'sd100, 16'd7);
    run_div(32'd100, -16'sd7);
    run_div(-32'sd100, -16'sd7);
    run_div(32'h8000_0000, 16'hFFFF);   // R3 overflow wrap
    run_div(32'h8000_0000, 16'h8000);
    run_div(32'h7FFF_FFFF, 16'h0001);
    run_div(32'h1234_8765, 16'h0000);   // R6
    run_div(32'h0000_0005, 16'h0003);   // R7 flag clears
    run_div(32'h0, 16'h8000);

    // R9: writes to read-only registers ignored
    rd(5'h08, prev_q);
    wr(5'h08, 32'h5555_5555); rd(5'h08, v); check("R9 quotient write ignored", v, prev_q);
    wr(5'h0C, 32'h5555_5555); rd(5'h0C, v); check("R9 remainder write ignored", v, exp_rem(32'h0, 16'h8000));
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, v); check("R9 status write ignored", v, 32'h0);
    check("R9 status write no start", {31'b0, div_busy}, 0);
    wr(5'h14, 32'hFFFF_FFFF); rd(5'h14, v); check("R9 unmapped reads zero", v, 32'h0);

    // R5 and R8: hold during busy, restart on second divisor write
    wr(5'h00, 32'd1000); wr(5'h04, 32'd7);
    repeat (5) @(negedge clk);
    rd(5'h08, v); check("R5 quotient held", v, prev_q);
    rd(5'h0C, v); check("R5 remainder held", v, exp_rem(32'h0, 16'h8000));
    wr(5'h00, -32'sd5000);
    wr(5'h04, 32'd3);
    cyc = 0;
    while (div_busy && cyc < 100) begin cyc++; @(negedge clk); end
    check("R8 busy from restart", cyc, 32);
    rd(5'h08, v); check("R8 quotient", v, exp_quo(-32'sd5000, 16'd3));
    rd(5'h0C, v); check("R8 remainder", v, exp_rem(-32'sd5000, 16'd3));

    // Random operands
    for (int i = 0; i < 150; i++) begin
      logic [31:0] d;
      logic [15:0] s;
      d = $urandom();
      case ($urandom_range(0, 9))
        0: s = 16'h0;
        1: s = 16'h0001;
        2: s = 16'hFFFF;
        3: s = 16'h8000;
        default: s = 16'($urandom());
      endcase
      if ($urandom_range(0, 9) == 0) d = 32'h8000_0000;
      run_div(d, s);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule